// File: doc/BRIEF.md
# Layered Tree Serializer

This block turns a decision tree, held in a node memory addressed by layer and by node index within the layer, into a stream of 512-bit words for a memory writer. A start pulse launches one pass. The block reads the per-layer node counts from a flat input vector and walks the layers in order. It fetches each node through a registered-read memory port and emits the tree in breadth-first order.

Each internal node has two fields rewritten on the way out. Its child pointer is stored relative to the next layer and becomes an absolute breadth-first index. Its quantized threshold index is replaced by a full-precision value read from a threshold table. Leaves pass through untouched. The first word carries the node total. After it, every word holds two nodes. A one-cycle done strobe marks the end of the pass.

Top module: `bfs_tree_packer`

## Requirements
- R1: After reset, out_valid_o, done_o, node_rd_o and lut_rd_o are all low.
- R2: The first word of a pass holds the total node count, which is the sum of all layer counts, zero-extended to 512 bits.
- R3: Nodes are emitted with layer 0 first and in ascending node index within each layer. Empty layers are skipped. A node read is issued only for an index below its layer's count. The count for layer L sits in bits [L*(ID_W+1) +: ID_W+1] of layer_cnt_i.
- R4: After the count word, each word holds two nodes, and the earlier node goes in bits [255:0]. Each 256-bit node slot carries the info field in bits [71:0] and the threshold in bits [191:128]. All other bits of the slot are zero.
- R5: When the total is odd, bits [511:256] of the last word are zero.
- R6: For an internal node (info bit 0 = 0), the 40-bit child field in info bits [71:32] is output as the node count of all layers up to and including the node's own layer, plus the stored relative value.
- R7: For an internal node, the output threshold is the table entry at address {feature, qidx}. The feature is info bits [8 +: FEAT_W] and takes the high address bits. The qidx is stored threshold bits [Q_W-1:0].
- R8: A leaf (info bit 0 = 1) is output with its info field and threshold exactly as stored.
- R9: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o holds its value.
- R10: done_o pulses for exactly one cycle after the last word has been accepted. A pass with a total of zero emits only the count word and then done_o.
- R11: A start_i pulse during a pass has no effect on the words emitted or on their number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a pass (honoured only when idle) |
| layer_cnt_i | input | DEPTH*(ID_W+1) | Per-layer node counts, held stable during a pass |
| node_rd_o | output | 1 | Node memory read strobe |
| node_layer_o | output | $clog2(DEPTH) | Layer of the node being read |
| node_id_o | output | ID_W | Node index within the layer |
| node_rdata_i | input | 136 | Node read data, one cycle after the strobe: {threshold[63:0], info[71:0]} |
| lut_rd_o | output | 1 | Threshold table read strobe |
| lut_addr_o | output | FEAT_W+Q_W | Threshold table address |
| lut_rdata_i | input | 64 | Table data, one cycle after the strobe |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Consumer ready |
| out_data_o | output | 512 | Output word |
| done_o | output | 1 | End-of-pass strobe |

## Verification
Two things can land together here: the back-pressure hold on an output word, and the end of the node list. When the total is odd, the half-filled last word is released exactly when the walker runs off the final layer. The bench sweeps layer-count shapes, including odd and even totals, empty middle and trailing layers, a zero total and a full tree. It runs these under three ready patterns, so that stalls fall on the final word and on the count word. Every word is compared with an image built arithmetically in the bench, and the bench checks that exactly one done pulse follows the final accepted word.

// File: rtl/bfs_tree_packer.sv
module bfs_tree_packer #(
  parameter int DEPTH  = 4,
  parameter int ID_W   = 4,
  parameter int FEAT_W = 4,
  parameter int Q_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [DEPTH*(ID_W+1)-1:0]     layer_cnt_i,
  output logic                          node_rd_o,
  output logic [$clog2(DEPTH)-1:0]      node_layer_o,
  output logic [ID_W-1:0]               node_id_o,
  input  logic [135:0]                  node_rdata_i,
  output logic                          lut_rd_o,
  output logic [FEAT_W+Q_W-1:0]         lut_addr_o,
  input  logic [63:0]                   lut_rdata_i,
  output logic                          out_valid_o,
  input  logic                          out_ready_i,
  output logic [511:0]                  out_data_o,
  output logic                          done_o
);
  localparam int CNT_W = ID_W + 1;
  localparam int LA_W  = $clog2(DEPTH);
  localparam int LC_W  = $clog2(DEPTH + 1);
  localparam int TOT_W = CNT_W + $clog2(DEPTH) + 1;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_NEXT, S_RD, S_LUT, S_CAP, S_OUT, S_DONE} st_t;

  st_t              st;
  logic [LC_W-1:0]  layer;
  logic [CNT_W-1:0] id;
  logic [TOT_W-1:0] base;
  logic             half;
  logic [135:0]     node_q;
  logic [511:0]     word;
  logic [TOT_W-1:0] total;
  logic [CNT_W-1:0] cur_cnt;
  logic [LA_W-1:0]  lsel;
  logic [71:0]      info_n;
  logic [63:0]      thr_n;
  logic [255:0]     slot;

  always_comb begin
    total = '0;
    for (int l = 0; l < DEPTH; l++)
      total = total + TOT_W'(layer_cnt_i[l*CNT_W +: CNT_W]);
  end

  assign lsel    = layer[LA_W-1:0];
  assign cur_cnt = layer_cnt_i[32'(lsel)*CNT_W +: CNT_W];

  always_comb begin
    info_n = node_q[71:0];
    thr_n  = node_q[135:72];
    if (!node_q[0]) begin
      info_n[71:32] = 40'(base + TOT_W'(cur_cnt)) + node_q[71:32];
      thr_n         = lut_rdata_i;
    end
    slot = {64'b0, thr_n, 56'b0, info_n};
  end

  assign node_rd_o    = (st == S_RD);
  assign node_layer_o = lsel;
  assign node_id_o    = id[ID_W-1:0];
  assign lut_rd_o     = (st == S_LUT) && !node_rdata_i[0];
  assign lut_addr_o   = {node_rdata_i[8 +: FEAT_W], node_rdata_i[72 +: Q_W]};
  assign out_valid_o  = (st == S_HDR) || (st == S_OUT);
  assign out_data_o   = word;
  assign done_o       = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      layer  <= '0;
      id     <= '0;
      base   <= '0;
      half   <= 1'b0;
      node_q <= '0;
      word   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          word  <= 512'(total);
          layer <= '0;
          id    <= '0;
          base  <= '0;
          half  <= 1'b0;
          st    <= S_HDR;
        end
        S_HDR, S_OUT: if (out_ready_i) st <= S_NEXT;
        S_NEXT: begin
          if (layer == LC_W'(DEPTH)) begin
            if (half) begin
              half <= 1'b0;
              st   <= S_OUT;
            end else begin
              st <= S_DONE;
            end
          end else if (id < cur_cnt) begin
            st <= S_RD;
          end else begin
            layer <= layer + 1'b1;
            id    <= '0;
            base  <= base + TOT_W'(cur_cnt);
          end
        end
        S_RD:  st <= S_LUT;
        S_LUT: begin
          node_q <= node_rdata_i;
          st     <= S_CAP;
        end
        S_CAP: begin
          id <= id + 1'b1;
          if (!half) begin
            word <= {256'b0, slot};
            half <= 1'b1;
            st   <= S_NEXT;
          end else begin
            word[511:256] <= slot;
            half <= 1'b0;
            st   <= S_OUT;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bfs_tree_packer_chk.sv
module bfs_tree_packer_chk #(
  parameter int DEPTH  = 4,
  parameter int ID_W   = 4,
  parameter int FEAT_W = 4,
  parameter int Q_W    = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [DEPTH*(ID_W+1)-1:0] layer_cnt_i,
  input logic                      node_rd_o,
  input logic [$clog2(DEPTH)-1:0]  node_layer_o,
  input logic [ID_W-1:0]           node_id_o,
  input logic                      lut_rd_o,
  input logic                      out_valid_o,
  input logic                      out_ready_i,
  input logic [511:0]              out_data_o,
  input logic                      done_o
);
  localparam int CNT_W = ID_W + 1;
  logic [CNT_W-1:0] rd_cnt;
  assign rd_cnt = layer_cnt_i[32'(node_layer_o)*CNT_W +: CNT_W];

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  assert_rd_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    node_rd_o |-> ({1'b0, node_id_o} < rd_cnt));

  assert_done_alone_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !out_valid_o);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_lut_after_node_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lut_rd_o |-> $past(node_rd_o));

  assert_one_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({node_rd_o, lut_rd_o, out_valid_o, done_o}));
endmodule

bind bfs_tree_packer bfs_tree_packer_chk #(
  .DEPTH(DEPTH), .ID_W(ID_W), .FEAT_W(FEAT_W), .Q_W(Q_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .layer_cnt_i(layer_cnt_i),
  .node_rd_o(node_rd_o), .node_layer_o(node_layer_o), .node_id_o(node_id_o),
  .lut_rd_o(lut_rd_o), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .out_data_o(out_data_o), .done_o(done_o)
);

// File: tb/bfs_tree_packer_tb.sv
module bfs_tree_packer_tb;
  localparam int DEPTH = 4, ID_W = 4, FEAT_W = 4, Q_W = 8, CNT_W = ID_W + 1;

  logic clk = 0, rst_n = 0, start_i = 0, out_ready_i = 0;
  logic [DEPTH*CNT_W-1:0] layer_cnt_i = '0;
  logic node_rd_o, lut_rd_o, out_valid_o, done_o;
  logic [1:0] node_layer_o;
  logic [ID_W-1:0] node_id_o;
  logic [135:0] node_rdata_i = '0;
  logic [FEAT_W+Q_W-1:0] lut_addr_o;
  logic [63:0] lut_rdata_i = '0;
  logic [511:0] out_data_o;

  int checks = 0, fails = 0;
  logic [511:0] exp_w [0:40];
  int n_exp;

  always #5 clk = ~clk;

  bfs_tree_packer #(.DEPTH(DEPTH), .ID_W(ID_W), .FEAT_W(FEAT_W), .Q_W(Q_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .layer_cnt_i(layer_cnt_i),
    .node_rd_o(node_rd_o), .node_layer_o(node_layer_o), .node_id_o(node_id_o),
    .node_rdata_i(node_rdata_i), .lut_rd_o(lut_rd_o), .lut_addr_o(lut_addr_o),
    .lut_rdata_i(lut_rdata_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_data_o(out_data_o), .done_o(done_o));

  function automatic logic [135:0] node_fn(int l, int i);
    logic [71:0] info;
    logic [63:0] thr;
    logic leaf;
    leaf = (l == DEPTH - 1) || (((l + i) % 3) == 0);
    info = '0;
    info[0] = leaf;
    info[15:8] = leaf ? 8'(l * 3 + i) : 8'((l * 5 + i) % 16);
    info[71:32] = 40'(i * 2 + (leaf ? 7 : 0));
    thr = {56'(l * 1000 + i + 1), 8'((l * 37 + i * 11) % 256)};
    return {thr, info};
  endfunction

  function automatic logic [63:0] lut_fn(logic [FEAT_W+Q_W-1:0] a);
    return 64'h0123_4567_0000_0000 ^ (64'(a) * 64'h9E37_79B9);
  endfunction

  always @(posedge clk) begin
    if (node_rd_o) node_rdata_i <= node_fn(int'(node_layer_o), int'(node_id_o));
    if (lut_rd_o) lut_rdata_i <= lut_fn(lut_addr_o);
  end

  task automatic check(bit ok, string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic build(int c[DEPTH]);
    int total = 0, base = 0, k = 1, half = 0;
    logic [511:0] cur = '0;
    for (int l = 0; l < DEPTH; l++) total += c[l];
    exp_w[0] = 512'(total);                        // R2
    for (int l = 0; l < DEPTH; l++) begin
      int nb = base + c[l];
      for (int i = 0; i < c[l]; i++) begin
        logic [135:0] n = node_fn(l, i);
        logic [71:0] info = n[71:0];
        logic [63:0] thr = n[135:72];
        logic [255:0] e;
        if (!info[0]) begin                         // R6, R7
          info[71:32] = 40'(nb) + n[71:32];
          thr = lut_fn({info[8 +: FEAT_W], n[72 +: Q_W]});
        end
        e = {64'b0, thr, 56'b0, info};              // R4, R8
        if (half == 0) begin cur = {256'b0, e}; half = 1; end
        else begin cur[511:256] = e; exp_w[k++] = cur; half = 0; end
      end
      base = nb;
    end
    if (half == 1) exp_w[k++] = cur;                // R5
    n_exp = k;
  endtask

  task automatic run(int c0, int c1, int c2, int c3, int mode, bit restart);
    int c[DEPTH];
    int got = 0, dones = 0, cyc = 0;
    bit fin = 0;
    c[0] = c0; c[1] = c1; c[2] = c2; c[3] = c3;
    build(c);
    @(negedge clk);
    for (int l = 0; l < DEPTH; l++) layer_cnt_i[l*CNT_W +: CNT_W] = CNT_W'(c[l]);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    while (!fin && cyc < 3000) begin
      bit r;
      case (mode)
        0: r = 1;
        1: r = (cyc % 3) != 0;
        default: r = (cyc % 5) < 2;
      endcase
      start_i = restart && (cyc == 9 || cyc == 40);
      out_ready_i = r;
      #1;
      if (out_valid_o && r) begin
        if (got < n_exp)
          check(out_data_o === exp_w[got], got == 0 ? "R2" : "R3/R4/R5/R6/R7/R8",
                out_data_o, exp_w[got]);
        got++;
      end
      if (done_o) begin
        dones++;
        check(got == n_exp, "R10 done after last word", 512'(got), 512'(n_exp));
        fin = 1;
      end
      @(negedge clk);
      cyc++;
    end
    start_i = 0;
    out_ready_i = 0;
    repeat (3) begin
      if (done_o) dones++;
      @(negedge clk);
    end
    check(dones == 1, "R10 single done", 512'(dones), 512'd1);
    check(got == n_exp, restart ? "R11 word count" : "R3 word count", 512'(got), 512'(n_exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1;
    @(negedge clk);
    check({out_valid_o, done_o, node_rd_o, lut_rd_o} == 4'b0, "R1 reset",
          512'({out_valid_o, done_o, node_rd_o, lut_rd_o}), 512'd0);
    rst_n = 1;
    @(negedge clk);
    check({out_valid_o, done_o} == 2'b0, "R1 idle", 512'({out_valid_o, done_o}), 512'd0);
    for (int m = 0; m < 3; m++) begin
      run(1, 2, 4, 0, m, 0);
      run(1, 2, 2, 0, m, 0);
      run(1, 0, 3, 2, m, 0);
      run(0, 0, 0, 0, m, 0);        // R10 empty tree
      run(3, 5, 7, 1, m, 0);
    end
    run(16, 16, 16, 16, 1, 0);
    run(1, 2, 4, 8, 2, 1);          // R11 restart ignored
    run(2, 3, 0, 5, 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule